// File: doc/BRIEF.md
# Runahead Mode Controller

This block sits beside the retire stage of a simple in-order pipeline and decides when that pipeline runs ahead speculatively. A load that misses in the last-level cache does not stall the pipeline. The controller saves the program counter and the whole architectural register file, marks the load's destination register as poisoned, and lets the same hardware thread keep retiring instructions. Poison spreads through register dependences. Loads whose address sources are clean and that also miss become prefetch requests, so several independent misses are in flight at once. Stores are discarded while running ahead.

When the blocking miss data arrives, the controller restores the saved registers and clears all poison marks. It then asserts a one-cycle restart strobe that carries the saved program counter, so fetch resumes at the missing load, which now hits. The caches, branch prediction and datapath are outside the block. The environment presents each retiring instruction with its class, its register indices, its computed address, its result value and a last-level-miss flag. Retire and prefetch both use valid/ready handshakes.

The state machine has three states:
- NORMAL: ordinary execution.
- RUNAHEAD: speculative execution.
- RESTORE: a single restart cycle.

It has four transitions:
- NORMAL to RUNAHEAD, on a retiring missing load.
- RUNAHEAD to RESTORE, on miss return.
- RESTORE to NORMAL, which is unconditional.
- NORMAL and RUNAHEAD each hold in all other cases.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset the block is in NORMAL with `spec_mode`, `restart_valid` and `pf_valid` low, `ret_ready` high, and every register reading value 0 with its poison bit clear.
- R2: In NORMAL, a retiring load (class 2'b01) with `ret_miss` high moves the block to RUNAHEAD on that edge without deasserting `ret_ready`. It saves `ret_pc` and all register values, and poisons only the load's destination register. A load without `ret_miss` just writes its value and stays in NORMAL.
- R3: In RUNAHEAD, an ALU instruction (class 2'b00) writes its value to its destination, and that destination's poison bit becomes the OR of the poison bits of its two sources.
- R4: In RUNAHEAD, a load whose address source (`ret_src_a`) is poisoned issues no prefetch and poisons its destination.
- R5: In RUNAHEAD, a load with a clean address source and `ret_miss` high raises `pf_valid` with `pf_addr` equal to its address on the next cycle and poisons its destination. Back-to-back such loads each produce their own request, in order.
- R6: A pending prefetch keeps `pf_valid` high and `pf_addr` unchanged until `pf_ready` is seen. While it waits in RUNAHEAD, `ret_ready` is low.
- R7: A store (class 2'b10) retired in NORMAL raises `st_we` with `st_addr` equal to its address in that cycle. A store retired in RUNAHEAD never raises `st_we`.
- R8: A missing load retired in RUNAHEAD does not start a nested period. The mode stays RUNAHEAD and the saved program counter is kept.
- R9: `miss_return` in RUNAHEAD moves the block to RESTORE. There, registers hold their saved values with all poison bits clear, `restart_valid` is high for exactly one cycle with `restart_pc` equal to the saved program counter, and `ret_ready` is low. The block then returns to NORMAL.
- R10: `miss_return` in NORMAL is ignored: no restart strobe and no mode change.
- R11: In RUNAHEAD, a load with a clean address source and `ret_miss` low writes its value and clears its destination's poison bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | Retiring instruction present |
| ret_ready | output | 1 | Controller accepts the retiring instruction |
| ret_op | input | 2 | Class: 00 ALU, 01 load, 10 store, 11 no-op |
| ret_src_a | input | RIDX_W | First source register (address source for loads) |
| ret_src_b | input | RIDX_W | Second source register |
| ret_dst | input | RIDX_W | Destination register |
| ret_pc | input | PC_W | Program counter of the instruction |
| ret_addr | input | ADDR_W | Computed memory address |
| ret_miss | input | 1 | Load missed the last-level cache, no prefetch covering it |
| ret_wdata | input | DATA_W | Result value to write |
| miss_return | input | 1 | Blocking miss data has returned |
| spec_mode | output | 1 | Block is in RUNAHEAD |
| restart_valid | output | 1 | One-cycle fetch restart strobe |
| restart_pc | output | PC_W | Restart program counter |
| pf_valid | output | 1 | Prefetch request pending |
| pf_ready | input | 1 | Memory side accepts the prefetch |
| pf_addr | output | ADDR_W | Prefetch address |
| st_we | output | 1 | Architectural store enable |
| st_addr | output | ADDR_W | Architectural store address |
| rd_idx | input | RIDX_W | Register observation index |
| rd_data | output | DATA_W | Value of register `rd_idx` |
| rd_inv | output | 1 | Poison bit of register `rd_idx` |

## Verification
The bench builds the controller with eight 16-bit registers, 16-bit addresses and a 12-bit program counter. With only eight registers, a short program can reach every index, including register 0 as a prefetch destination. Its mix of clean, poisoned and overwritten registers then shows that restoring the saved registers rolls back all of them. The narrow widths keep prefetch and restart addresses easy to recognise. A held `pf_ready` makes the stall path reachable within a few cycles.

// File: rtl/ra_pkg.sv
`timescale 1ns/1ps
package ra_pkg;
    typedef enum logic [1:0] {
        OP_ALU   = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_NOP   = 2'b11
    } op_class_e;

    typedef enum logic [1:0] {
        ST_NORMAL   = 2'b00,
        ST_RUNAHEAD = 2'b01,
        ST_RESTORE  = 2'b10
    } ra_state_e;
endpackage

// File: rtl/ra_poison_tracker.sv
`timescale 1ns/1ps
module ra_poison_tracker #(
    parameter int NREGS  = 32,
    localparam int RIDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic              set_en,
    input  logic [RIDX_W-1:0] set_idx,
    input  logic              set_val,
    output logic [NREGS-1:0]  inv
);
    for (genvar g = 0; g < NREGS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                inv[g] <= 1'b0;
            end else if (set_en && set_idx == RIDX_W'(g)) begin
                inv[g] <= set_val;
            end else if (clear_all) begin
                inv[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ra_regfile_ckpt.sv
`timescale 1ns/1ps
module ra_regfile_ckpt #(
    parameter int NREGS  = 32,
    parameter int DATA_W = 32,
    localparam int RIDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              save,
    input  logic              restore,
    input  logic [RIDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] live [NREGS];
    logic [DATA_W-1:0] saved [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live[g]  <= '0;
                saved[g] <= '0;
            end else begin
                if (restore) begin
                    live[g] <= saved[g];
                end else if (wr_en && wr_idx == RIDX_W'(g)) begin
                    live[g] <= wr_data;
                end
                if (save) begin
                    saved[g] <= live[g];
                end
            end
        end
    end

    assign rd_data = live[rd_idx];
endmodule

// File: rtl/ra_pf_port.sv
`timescale 1ns/1ps
module ra_pf_port #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              busy
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else if (issue) begin
            pf_valid <= 1'b1;
            pf_addr  <= issue_addr;
        end else if (pf_ready) begin
            pf_valid <= 1'b0;
        end
    end

    assign busy = pf_valid && !pf_ready;
endmodule

// File: rtl/runahead_ctrl.sv
`timescale 1ns/1ps
module runahead_ctrl #(
    parameter int NREGS  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int PC_W   = 32,
    localparam int RIDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    output logic              ret_ready,
    input  logic [1:0]        ret_op,
    input  logic [RIDX_W-1:0] ret_src_a,
    input  logic [RIDX_W-1:0] ret_src_b,
    input  logic [RIDX_W-1:0] ret_dst,
    input  logic [PC_W-1:0]   ret_pc,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              ret_miss,
    input  logic [DATA_W-1:0] ret_wdata,
    input  logic              miss_return,
    output logic              spec_mode,
    output logic              restart_valid,
    output logic [PC_W-1:0]   restart_pc,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              st_we,
    output logic [ADDR_W-1:0] st_addr,
    input  logic [RIDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_inv
);
    import ra_pkg::*;

    ra_state_e state_q, state_d;
    op_class_e op;
    logic [NREGS-1:0] inv;
    logic [PC_W-1:0]  ckpt_pc_q;
    logic fire, pf_busy, src_a_inv, src_b_inv;
    logic enter, leave;
    logic rf_we, inv_clear, inv_set, inv_val, pf_issue;

    assign op        = op_class_e'(ret_op);
    assign fire      = ret_valid && ret_ready;
    assign src_a_inv = inv[ret_src_a];
    assign src_b_inv = inv[ret_src_b];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_NORMAL;
            ckpt_pc_q <= '0;
        end else begin
            state_q <= state_d;
            if (enter) begin
                ckpt_pc_q <= ret_pc;
            end
        end
    end

    // Next state and per-state control
    always_comb begin
        state_d   = state_q;
        ret_ready = 1'b0;
        enter     = 1'b0;
        leave     = 1'b0;
        rf_we     = 1'b0;
        inv_clear = 1'b0;
        inv_set   = 1'b0;
        inv_val   = 1'b0;
        pf_issue  = 1'b0;
        st_we     = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                ret_ready = 1'b1;
                if (fire) begin
                    unique case (op)
                        OP_ALU: rf_we = 1'b1;
                        OP_LOAD: begin
                            if (ret_miss) begin
                                enter     = 1'b1;
                                inv_clear = 1'b1;
                                inv_set   = 1'b1;
                                inv_val   = 1'b1;
                                state_d   = ST_RUNAHEAD;
                            end else begin
                                rf_we = 1'b1;
                            end
                        end
                        OP_STORE: st_we = 1'b1;
                        OP_NOP: ;
                    endcase
                end
            end
            ST_RUNAHEAD: begin
                ret_ready = !miss_return && !pf_busy;
                if (miss_return) begin
                    leave     = 1'b1;
                    inv_clear = 1'b1;
                    state_d   = ST_RESTORE;
                end else if (fire) begin
                    unique case (op)
                        OP_ALU: begin
                            rf_we   = 1'b1;
                            inv_set = 1'b1;
                            inv_val = src_a_inv || src_b_inv;
                        end
                        OP_LOAD: begin
                            inv_set  = 1'b1;
                            inv_val  = src_a_inv || ret_miss;
                            rf_we    = !src_a_inv && !ret_miss;
                            pf_issue = !src_a_inv && ret_miss;
                        end
                        OP_STORE: ;
                        OP_NOP: ;
                    endcase
                end
            end
            ST_RESTORE: begin
                state_d = ST_NORMAL;
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    // Outputs
    always_comb begin
        spec_mode     = (state_q == ST_RUNAHEAD);
        restart_valid = (state_q == ST_RESTORE);
        restart_pc    = ckpt_pc_q;
        st_addr       = ret_addr;
        rd_inv        = inv[rd_idx];
    end

    ra_poison_tracker #(.NREGS(NREGS)) u_poison (
        .clk(clk), .rst_n(rst_n), .clear_all(inv_clear), .set_en(inv_set),
        .set_idx(ret_dst), .set_val(inv_val), .inv(inv)
    );

    ra_regfile_ckpt #(.NREGS(NREGS), .DATA_W(DATA_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(rf_we), .wr_idx(ret_dst),
        .wr_data(ret_wdata), .save(enter), .restore(leave),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    ra_pf_port #(.ADDR_W(ADDR_W)) u_pf (
        .clk(clk), .rst_n(rst_n), .issue(pf_issue), .issue_addr(ret_addr),
        .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr),
        .busy(pf_busy)
    );
endmodule

// File: rtl/runahead_ctrl_checker.sv
`timescale 1ns/1ps
module runahead_ctrl_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ret_valid,
    input logic              ret_ready,
    input logic [1:0]        ret_op,
    input logic              ret_miss,
    input logic              miss_return,
    input logic              spec_mode,
    input logic              restart_valid,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              st_we
);
    assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !spec_mode && !restart_valid && ret_valid && ret_ready && ret_op == 2'b01 && ret_miss
        |=> spec_mode);

    assert_pf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

    assert_pf_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spec_mode && pf_valid && !pf_ready |-> !ret_ready);

    assert_no_spec_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spec_mode |-> !st_we);

    assert_no_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spec_mode && !miss_return |=> spec_mode && !restart_valid);

    assert_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        spec_mode && miss_return |=> restart_valid && !spec_mode && !ret_ready);

    assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |=> !restart_valid && !spec_mode);

    assert_ignore_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !spec_mode && miss_return |=> !restart_valid);
endmodule

bind runahead_ctrl runahead_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_ready(ret_ready),
    .ret_op(ret_op), .ret_miss(ret_miss), .miss_return(miss_return),
    .spec_mode(spec_mode), .restart_valid(restart_valid), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_addr(pf_addr), .st_we(st_we)
);

// File: tb/runahead_ctrl_bench.sv
`timescale 1ns/1ps
module runahead_ctrl_bench;
    localparam int NREGS = 8, DATA_W = 16, ADDR_W = 16, PC_W = 12;
    localparam int RIDX_W = $clog2(NREGS);

    logic clk = 1'b0, rst_n = 1'b0;
    logic ret_valid = 1'b0, ret_ready;
    logic [1:0] ret_op = 2'b11;
    logic [RIDX_W-1:0] ret_src_a = '0, ret_src_b = '0, ret_dst = '0, rd_idx = '0;
    logic [PC_W-1:0] ret_pc = '0, restart_pc;
    logic [ADDR_W-1:0] ret_addr = '0, pf_addr, st_addr;
    logic ret_miss = 1'b0, miss_return = 1'b0, pf_ready = 1'b1;
    logic [DATA_W-1:0] ret_wdata = '0, rd_data;
    logic spec_mode, restart_valid, pf_valid, st_we, rd_inv;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [ADDR_W-1:0] exp_q[$];

    always #2 clk = ~clk;

    runahead_ctrl #(.NREGS(NREGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PC_W(PC_W)) u_runahead_ctrl (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_ready(ret_ready),
        .ret_op(ret_op), .ret_src_a(ret_src_a), .ret_src_b(ret_src_b),
        .ret_dst(ret_dst), .ret_pc(ret_pc), .ret_addr(ret_addr),
        .ret_miss(ret_miss), .ret_wdata(ret_wdata), .miss_return(miss_return),
        .spec_mode(spec_mode), .restart_valid(restart_valid),
        .restart_pc(restart_pc), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_addr(pf_addr), .st_we(st_we), .st_addr(st_addr),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_inv(rd_inv)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_reg(input int idx, input logic [DATA_W-1:0] val, input logic inv_e,
                             input string req, input bit wait_edge);
        if (wait_edge) @(negedge clk);
        rd_idx = RIDX_W'(idx);
        #0.2;
        check(rd_data == val, req, 32'(rd_data), 32'(val));
        check(rd_inv == inv_e, req, 32'(rd_inv), 32'(inv_e));
    endtask

    // Driver: presents one retiring instruction, waits for acceptance
    task automatic retire(input logic [1:0] op, input int sa, input int sb, input int d,
                          input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] addr,
                          input logic miss, input logic [DATA_W-1:0] wd, input bit expect_pf);
        ret_valid = 1'b1; ret_op = op;
        ret_src_a = RIDX_W'(sa); ret_src_b = RIDX_W'(sb); ret_dst = RIDX_W'(d);
        ret_pc = pc; ret_addr = addr; ret_miss = miss; ret_wdata = wd;
        if (expect_pf) exp_q.push_back(addr);
        #0.2;
        while (!ret_ready) begin
            @(negedge clk);
            #0.2;
        end
        @(posedge clk);
        @(negedge clk);
        ret_valid = 1'b0; ret_op = 2'b11; ret_miss = 1'b0;
    endtask

    // Monitor: pops expected prefetch addresses as requests are accepted
    always @(negedge clk) begin
        if (rst_n && pf_valid && pf_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected prefetch", 32'(pf_addr), 32'hffff_ffff);
            end else begin
                logic [ADDR_W-1:0] e;
                e = exp_q.pop_front();
                check(pf_addr == e, "R5 prefetch address", 32'(pf_addr), 32'(e));
            end
        end
    end

    initial begin
        #(4 * 5000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.2;
        // R1 reset state
        check(!spec_mode && !restart_valid && !pf_valid, "R1 reset flags", {29'b0, spec_mode, restart_valid, pf_valid}, 0);
        check(ret_ready, "R1 ret_ready", 32'(ret_ready), 1);
        check_reg(3, 16'h0, 1'b0, "R1 reg reset", 1'b0);

        // Normal-mode writes
        retire(2'b00, 0, 0, 1, 12'h010, 16'h0, 1'b0, 16'h0011, 1'b0);
        retire(2'b00, 0, 0, 2, 12'h011, 16'h0, 1'b0, 16'h0022, 1'b0);
        retire(2'b00, 0, 0, 3, 12'h012, 16'h0, 1'b0, 16'h0033, 1'b0);
        check_reg(1, 16'h0011, 1'b0, "R2 normal write", 1'b0);

        // R7 normal store commits
        ret_valid = 1'b1; ret_op = 2'b10; ret_addr = 16'h0bee; #0.2;
        check(st_we && st_addr == 16'h0bee, "R7 normal store", {st_we, 15'b0, st_addr}, 32'h8000_0bee);
        @(posedge clk); @(negedge clk); ret_valid = 1'b0; ret_op = 2'b11;

        // R10 miss return in NORMAL ignored
        miss_return = 1'b1; @(negedge clk); miss_return = 1'b0;
        check(!restart_valid && !spec_mode, "R10 ignored return", {restart_valid, spec_mode}, 0);

        // R2 enter on missing load
        retire(2'b01, 1, 0, 4, 12'h020, 16'h4000, 1'b1, 16'hdead, 1'b0);
        check(spec_mode && ret_ready, "R2 entry", {spec_mode, ret_ready}, 3);
        check_reg(4, 16'h0, 1'b1, "R2 dst poisoned", 1'b0);
        check_reg(1, 16'h0011, 1'b0, "R2 other clean", 1'b0);

        // R3 poison propagation
        retire(2'b00, 4, 2, 5, 12'h021, 16'h0, 1'b0, 16'h0055, 1'b0);
        check_reg(5, 16'h0055, 1'b1, "R3 poisoned source", 1'b0);
        retire(2'b00, 2, 3, 1, 12'h022, 16'h0, 1'b0, 16'h0077, 1'b0);
        check_reg(1, 16'h0077, 1'b0, "R3 clean sources", 1'b0);

        // R4 poisoned address: no request
        retire(2'b01, 5, 0, 6, 12'h023, 16'h0099, 1'b1, 16'h0, 1'b0);
        check(!pf_valid, "R4 no prefetch", 32'(pf_valid), 0);
        check_reg(6, 16'h0, 1'b1, "R4 dst poisoned", 1'b0);

        // R5 / R8 independent misses become prefetches, no nesting
        retire(2'b01, 2, 0, 7, 12'h024, 16'h1234, 1'b1, 16'h0, 1'b1);
        retire(2'b01, 3, 0, 0, 12'h025, 16'h2468, 1'b1, 16'h0, 1'b1);
        check(spec_mode, "R8 still speculative", 32'(spec_mode), 1);
        check_reg(7, 16'h0, 1'b1, "R5 prefetch dst poisoned", 1'b0);

        // R11 hit load in RUNAHEAD
        retire(2'b01, 3, 0, 2, 12'h026, 16'h0300, 1'b0, 16'h4242, 1'b0);
        check_reg(2, 16'h4242, 1'b0, "R11 hit load", 1'b0);

        // R7 store dropped in RUNAHEAD
        ret_valid = 1'b1; ret_op = 2'b10; ret_addr = 16'h0c0c; #0.2;
        check(!st_we, "R7 spec store dropped", 32'(st_we), 0);
        @(posedge clk); @(negedge clk); ret_valid = 1'b0; ret_op = 2'b11;

        // R6 held prefetch stalls retire
        pf_ready = 1'b0;
        retire(2'b01, 1, 0, 3, 12'h027, 16'h0abc, 1'b1, 16'h0, 1'b1);
        ret_valid = 1'b1; ret_op = 2'b00; ret_dst = 3'd6; #0.2;
        check(pf_valid && !ret_ready, "R6 stall while held", {pf_valid, ret_ready}, 2);
        repeat (3) @(negedge clk);
        check(pf_valid && pf_addr == 16'h0abc, "R6 request held", {pf_valid, 15'b0, pf_addr}, 32'h8000_0abc);
        check(!ret_ready, "R6 still stalled", 32'(ret_ready), 0);
        @(posedge clk); #0.2; pf_ready = 1'b1;
        @(negedge clk);
        @(posedge clk); @(negedge clk);
        ret_valid = 1'b0; ret_op = 2'b11;
        check(!pf_valid, "R6 released", 32'(pf_valid), 0);

        // R9 rollback
        miss_return = 1'b1; @(negedge clk); miss_return = 1'b0; #0.2;
        check(restart_valid && !spec_mode && !ret_ready, "R9 restore state",
              {restart_valid, spec_mode, ret_ready}, 4);
        check(restart_pc == 12'h020, "R8 R9 restart pc", 32'(restart_pc), 32'h020);
        check_reg(1, 16'h0011, 1'b0, "R9 r1 restored", 1'b0);
        check_reg(2, 16'h0022, 1'b0, "R9 r2 restored", 1'b0);
        check_reg(4, 16'h0000, 1'b0, "R9 r4 restored", 1'b0);
        check_reg(5, 16'h0000, 1'b0, "R9 r5 restored", 1'b0);
        @(negedge clk);
        check(!restart_valid && !spec_mode && ret_ready, "R9 single pulse",
              {restart_valid, spec_mode, ret_ready}, 1);

        // R2 re-executed load now hits
        retire(2'b01, 1, 0, 4, 12'h020, 16'h4000, 1'b0, 16'h0044, 1'b0);
        check(!spec_mode, "R2 hit stays normal", 32'(spec_mode), 0);
        check_reg(4, 16'h0044, 1'b0, "R2 hit value", 1'b0);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R5 all prefetches seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule